// File: doc/BRIEF.md
# Serial Security Key Unlock Gate

This block decides whether on-chip program memory may be used after power-on. A host sends key bytes over a byte-wide receive stream. The block returns each byte after a fixed delay and compares it with one stored key byte, in order. When the last key byte has been echoed, the block sends a break character and then sets or clears the unlock flag. The break is sent whether the key matched or not, and it tells the host that the device is ready for commands. While locked, reads inside the protected address window return a fixed invalid value, and an instruction fetch from that window requests an illegal-address reset.

Each power-on allows one attempt. A warm reset cannot start a new one. A warm reset during key entry ends the attempt as failed. Once the attempt is over, incoming bytes are accepted and dropped without an echo. A mass-erase pulse sets every stored key byte to 0xFF, the blank key.

Both streams use valid/ready. A byte moves on a clock edge where valid and ready are both high. `rx_ready` stays low while an echo or the break is waiting or being offered, so only one byte is ever in flight. Once `tx_valid` is high, `tx_data` and `tx_break` hold their values until `tx_ready` accepts them. The only exception is a warm reset, which withdraws the offer.

Top module: `skg_gate`

## Requirements
- R1: Each of the first NKEY accepted bytes is offered on the transmit stream with `tx_break`=0 and `tx_data` equal to the byte. `tx_valid` rises exactly ECHO_CYC = 2*BIT_CYCLES clock edges after the edge that accepted the byte.
- R2: The break is offered only after the echo of byte NKEY has been accepted. It appears ECHO_CYC edges after that handshake, with `tx_break`=1 and `tx_data`=0x00. No break is offered before then.
- R3: The break is sent whether the compare passed or failed.
- R4: Received byte i (counting from 0) is compared with key byte i, which is bits [8i+7:8i] of KEY_INIT or of the erased key. The flag is `stat_byte` bit 6, and the other bits of `stat_byte` read 0. In the cycle after the break handshake, `entry_done` is high for exactly one cycle. In that same cycle the flag becomes 1 if all NKEY bytes matched and 0 otherwise. The flag keeps that value until the next power-on reset.
- R5: While locked, a read address in [PROT_LO, PROT_HI] gives `mem_rdata_out`=0xAD. Any other address, or any address while unlocked, passes `mem_rdata_in` through unchanged. The path is combinational.
- R6: A fetch from [PROT_LO, PROT_HI] while locked makes `rst_req` high in the next cycle. Fetches outside the window, or any fetch while unlocked, leave `rst_req` at 0.
- R7: Only one attempt is allowed per power-on.
  - After the attempt ends, received bytes are accepted and dropped: there is no echo and no change of status.
  - A warm reset (`wrst_n`=0) leaves the status flag as it is and does not re-arm key entry.
  - A warm reset during key entry ends the attempt as failed, with no break and no `entry_done` pulse.
- R8: An `erase_req` pulse sets all NKEY key bytes to 0xFF, so NKEY bytes of 0xFF then unlock.
- R9: While `tx_valid` is high and `tx_ready` is low, `tx_valid`, `tx_data` and `tx_break` hold their values. `rx_ready` is low from the edge that accepts a key byte until its echo (and, for the last byte, the break) has been accepted.
- R10: After power-on reset: `stat_byte`=0x00, `tx_valid`=0, `rx_ready`=1, `rst_req`=0, `entry_done`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| por_n | input | 1 | Power-on reset, active low, asynchronous; re-arms key entry |
| wrst_n | input | 1 | Warm reset, active low, synchronous; never re-arms entry |
| rx_valid | input | 1 | Received byte available |
| rx_data | input | 8 | Received byte |
| rx_ready | output | 1 | Block can take a received byte |
| tx_valid | output | 1 | Echo or break offered |
| tx_ready | input | 1 | Transmitter takes the offer |
| tx_data | output | 8 | Echo byte, 0x00 for break |
| tx_break | output | 1 | Offer is a break character |
| erase_req | input | 1 | Mass-erase pulse: key becomes all 0xFF |
| mem_addr | input | ADDR_W | Read address |
| mem_rdata_in | input | 8 | Data from program memory |
| mem_rdata_out | output | 8 | Data to the reader, overridden while locked |
| fetch_valid | input | 1 | Instruction fetch strobe |
| fetch_addr | input | ADDR_W | Fetch address |
| rst_req | output | 1 | Illegal-address reset request |
| stat_byte | output | 8 | Status byte, bit 6 = unlocked |
| entry_done | output | 1 | One-cycle pulse when key entry completes |

## Verification
The assertions check on every cycle the properties that do not depend on the key:
- the transmit offer is held under back-pressure;
- a break never appears before byte NKEY has been counted;
- nothing is transmitted once the attempt is over;
- the flag is unlocked only in the finished state and never changes there;
- an erase pulse leaves a blank key byte behind;
- a locked fetch from the window raises the reset request.

Only the bench scenarios can show that the outcome is right for a given key: a correct key, a wrong last byte, a wrong first byte, a blank key after erase, and a refused retry after a warm reset. The same holds for the exact echo and break delays.

// File: rtl/skg_pkg.sv
package skg_pkg;
  typedef enum logic [2:0] {
    S_COLLECT   = 3'd0,
    S_ECHO_WAIT = 3'd1,
    S_ECHO      = 3'd2,
    S_BRK_WAIT  = 3'd3,
    S_BRK       = 3'd4,
    S_DONE      = 3'd5
  } skg_state_e;

  localparam logic [7:0] BAD_READ   = 8'hAD;
  localparam logic [7:0] BREAK_BYTE = 8'h00;
  localparam logic [7:0] BLANK_BYTE = 8'hFF;
  localparam int         FLAG_BIT   = 6;
endpackage

// File: rtl/skg_keystore.sv
module skg_keystore #(
  parameter int          NKEY     = 8,
  parameter logic [63:0] KEY_INIT = 64'h0,
  localparam int         IW       = (NKEY > 1) ? $clog2(NKEY) : 1
) (
  input  logic          clk,
  input  logic          por_n,
  input  logic          erase_req,
  input  logic [IW-1:0] key_idx,
  output logic [7:0]    key_byte
);
  import skg_pkg::*;

  logic [7:0] key_q [NKEY];

  for (genvar g = 0; g < NKEY; g++) begin : g_key
    always_ff @(posedge clk or negedge por_n) begin
      if (!por_n)         key_q[g] <= KEY_INIT[8*g +: 8];
      else if (erase_req) key_q[g] <= BLANK_BYTE;
    end
  end

  assign key_byte = key_q[key_idx];

  // R8: after an erase pulse, whichever byte is selected reads blank
  p_erase_blank_r8: assert property (@(posedge clk) disable iff (!por_n)
    erase_req |=> (key_byte == BLANK_BYTE));
endmodule

// File: rtl/skg_ctrl.sv
module skg_ctrl #(
  parameter  int NKEY       = 8,
  parameter  int BIT_CYCLES = 4,
  localparam int ECHO_CYC   = 2 * BIT_CYCLES,
  localparam int DW         = $clog2(ECHO_CYC + 1),
  localparam int CW         = $clog2(NKEY + 1),
  localparam int IW         = (NKEY > 1) ? $clog2(NKEY) : 1
) (
  input  logic          clk,
  input  logic          por_n,
  input  logic          wrst_n,
  input  logic          rx_valid,
  input  logic [7:0]    rx_data,
  output logic          rx_ready,
  output logic          tx_valid,
  input  logic          tx_ready,
  output logic [7:0]    tx_data,
  output logic          tx_break,
  output logic [IW-1:0] key_idx,
  input  logic [7:0]    key_byte,
  output logic          unlocked,
  output logic          done
);
  import skg_pkg::*;

  skg_state_e    st;
  logic [CW-1:0] cnt;
  logic [DW-1:0] dly;
  logic [7:0]    hold;
  logic          fail;

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) begin
      st       <= S_COLLECT;
      cnt      <= '0;
      dly      <= '0;
      hold     <= '0;
      fail     <= 1'b0;
      unlocked <= 1'b0;
      done     <= 1'b0;
    end else begin
      done <= 1'b0;
      if (!wrst_n && st != S_DONE) begin
        st       <= S_DONE;
        fail     <= 1'b1;
        unlocked <= 1'b0;
      end else begin
        case (st)
          S_COLLECT: if (rx_valid) begin
            hold <= rx_data;
            if (rx_data != key_byte) fail <= 1'b1;
            cnt  <= cnt + CW'(1);
            dly  <= DW'(ECHO_CYC - 1);
            st   <= S_ECHO_WAIT;
          end
          S_ECHO_WAIT: if (dly == '0) st <= S_ECHO;
                       else           dly <= dly - DW'(1);
          S_ECHO: if (tx_ready) begin
            if (cnt == CW'(NKEY)) begin
              dly <= DW'(ECHO_CYC - 1);
              st  <= S_BRK_WAIT;
            end else begin
              st  <= S_COLLECT;
            end
          end
          S_BRK_WAIT: if (dly == '0) st <= S_BRK;
                      else           dly <= dly - DW'(1);
          S_BRK: if (tx_ready) begin
            st       <= S_DONE;
            done     <= 1'b1;
            unlocked <= !fail;
          end
          S_DONE: ;
          default: st <= S_DONE;
        endcase
      end
    end
  end

  assign key_idx  = cnt[IW-1:0];
  assign rx_ready = (st == S_COLLECT) || (st == S_DONE);
  assign tx_valid = (st == S_ECHO) || (st == S_BRK);
  assign tx_break = (st == S_BRK);
  assign tx_data  = (st == S_BRK) ? BREAK_BYTE : hold;

  // R2: a break is never offered before all key bytes are counted
  p_brk_after_all_r2: assert property (@(posedge clk) disable iff (!por_n)
    (tx_valid && tx_break) |-> (cnt == CW'(NKEY)));

  // R9: offer held under back-pressure (warm reset withdraws it)
  p_tx_hold_r9: assert property (@(posedge clk) disable iff (!por_n)
    (tx_valid && !tx_ready && wrst_n) |=>
      (tx_valid && $stable(tx_data) && $stable(tx_break)));

  // R7: nothing is transmitted once the attempt is over
  p_silent_after_r7: assert property (@(posedge clk) disable iff (!por_n)
    (st == S_DONE) |-> !tx_valid);

  // R4: flag never moves once the attempt has ended
  p_flag_stable_r4: assert property (@(posedge clk) disable iff (!por_n)
    (st == S_DONE) |=> $stable(unlocked));

  // R4: unlocked only in the finished state and never after a mismatch
  p_unlock_ok_r4: assert property (@(posedge clk) disable iff (!por_n)
    unlocked |-> (st == S_DONE && !fail));
endmodule

// File: rtl/skg_access.sv
module skg_access #(
  parameter int              ADDR_W  = 16,
  parameter logic [ADDR_W-1:0] PROT_LO = 16'hDC00,
  parameter logic [ADDR_W-1:0] PROT_HI = 16'hFBFF
) (
  input  logic              clk,
  input  logic              por_n,
  input  logic              locked,
  input  logic [ADDR_W-1:0] mem_addr,
  input  logic [7:0]        mem_rdata_in,
  output logic [7:0]        mem_rdata_out,
  input  logic              fetch_valid,
  input  logic [ADDR_W-1:0] fetch_addr,
  output logic              rst_req
);
  import skg_pkg::*;

  logic rd_hit, fe_hit;

  assign rd_hit = (mem_addr >= PROT_LO) && (mem_addr <= PROT_HI);
  assign fe_hit = (fetch_addr >= PROT_LO) && (fetch_addr <= PROT_HI);

  assign mem_rdata_out = (locked && rd_hit) ? BAD_READ : mem_rdata_in;

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) rst_req <= 1'b0;
    else        rst_req <= fetch_valid && fe_hit && locked;
  end

  // R6: a locked fetch inside the window raises the reset request
  p_fetch_reset_r6: assert property (@(posedge clk) disable iff (!por_n)
    (fetch_valid && locked && fetch_addr >= PROT_LO && fetch_addr <= PROT_HI)
      |=> rst_req);

  // R5: an unlocked reader always sees memory data
  p_pass_unlocked_r5: assert property (@(posedge clk) disable iff (!por_n)
    !locked |-> (mem_rdata_out == mem_rdata_in));
endmodule

// File: rtl/skg_gate.sv
module skg_gate #(
  parameter int                NKEY       = 8,
  parameter int                BIT_CYCLES = 4,
  parameter logic [63:0]       KEY_INIT   = 64'h3C5A_7E19_D2B4_8F06,
  parameter int                ADDR_W     = 16,
  parameter logic [ADDR_W-1:0] PROT_LO    = 16'hDC00,
  parameter logic [ADDR_W-1:0] PROT_HI    = 16'hFBFF,
  localparam int               IW         = (NKEY > 1) ? $clog2(NKEY) : 1
) (
  input  logic              clk,
  input  logic              por_n,
  input  logic              wrst_n,
  input  logic              rx_valid,
  input  logic [7:0]        rx_data,
  output logic              rx_ready,
  output logic              tx_valid,
  input  logic              tx_ready,
  output logic [7:0]        tx_data,
  output logic              tx_break,
  input  logic              erase_req,
  input  logic [ADDR_W-1:0] mem_addr,
  input  logic [7:0]        mem_rdata_in,
  output logic [7:0]        mem_rdata_out,
  input  logic              fetch_valid,
  input  logic [ADDR_W-1:0] fetch_addr,
  output logic              rst_req,
  output logic [7:0]        stat_byte,
  output logic              entry_done
);
  import skg_pkg::*;

  logic [IW-1:0] key_idx;
  logic [7:0]    key_byte;
  logic          unlocked;

  skg_keystore #(.NKEY(NKEY), .KEY_INIT(KEY_INIT)) u_keys (
    .clk(clk), .por_n(por_n), .erase_req(erase_req),
    .key_idx(key_idx), .key_byte(key_byte)
  );

  skg_ctrl #(.NKEY(NKEY), .BIT_CYCLES(BIT_CYCLES)) u_ctrl (
    .clk(clk), .por_n(por_n), .wrst_n(wrst_n),
    .rx_valid(rx_valid), .rx_data(rx_data), .rx_ready(rx_ready),
    .tx_valid(tx_valid), .tx_ready(tx_ready), .tx_data(tx_data),
    .tx_break(tx_break), .key_idx(key_idx), .key_byte(key_byte),
    .unlocked(unlocked), .done(entry_done)
  );

  skg_access #(.ADDR_W(ADDR_W), .PROT_LO(PROT_LO), .PROT_HI(PROT_HI)) u_acc (
    .clk(clk), .por_n(por_n), .locked(!unlocked),
    .mem_addr(mem_addr), .mem_rdata_in(mem_rdata_in),
    .mem_rdata_out(mem_rdata_out), .fetch_valid(fetch_valid),
    .fetch_addr(fetch_addr), .rst_req(rst_req)
  );

  always_comb begin
    stat_byte           = 8'h00;
    stat_byte[FLAG_BIT] = unlocked;
  end
endmodule

// File: tb/skg_gate_test.sv
module skg_gate_test;
  localparam int          NK   = 8;
  localparam int          BC   = 4;
  localparam int          DLY  = 2 * BC;
  localparam logic [63:0] KEY  = 64'h3C5A_7E19_D2B4_8F06;
  localparam logic [15:0] LO   = 16'hDC00;

  logic clk = 0, por_n = 0, wrst_n = 1;
  logic rx_valid = 0, tx_ready = 0, erase_req = 0, fetch_valid = 0;
  logic [7:0] rx_data = 0, mem_rdata_in = 8'h5C;
  logic [15:0] mem_addr = 0, fetch_addr = 0;
  logic rx_ready, tx_valid, tx_break, rst_req, entry_done;
  logic [7:0] tx_data, mem_rdata_out, stat_byte;
  int checks = 0, errors = 0;

  always #5 clk = ~clk;

  skg_gate #(.NKEY(NK), .BIT_CYCLES(BC), .KEY_INIT(KEY)) uut (
    .clk(clk), .por_n(por_n), .wrst_n(wrst_n), .rx_valid(rx_valid),
    .rx_data(rx_data), .rx_ready(rx_ready), .tx_valid(tx_valid),
    .tx_ready(tx_ready), .tx_data(tx_data), .tx_break(tx_break),
    .erase_req(erase_req), .mem_addr(mem_addr), .mem_rdata_in(mem_rdata_in),
    .mem_rdata_out(mem_rdata_out), .fetch_valid(fetch_valid),
    .fetch_addr(fetch_addr), .rst_req(rst_req), .stat_byte(stat_byte),
    .entry_done(entry_done)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic power_on();
    por_n = 0; wrst_n = 1; rx_valid = 0; tx_ready = 0;
    repeat (3) @(posedge clk);
    @(negedge clk) por_n = 1;
  endtask

  // Count negedges from just after an accepting edge until tx_valid is high.
  task automatic wait_tx(output int n);
    n = 0;
    @(negedge clk);
    while (!tx_valid && n < 100) begin n++; @(negedge clk); end
  endtask

  task automatic send_rx(input logic [7:0] b);
    @(negedge clk);
    rx_valid = 1; rx_data = b;
    @(posedge clk); #1 rx_valid = 0;
  endtask

  task automatic run_entry(input logic [63:0] v, input bit pass, input int stall);
    int n;
    for (int i = 0; i < NK; i++) begin
      send_rx(v[8*i +: 8]);
      wait_tx(n);
      chk(n == DLY, "R1", "echo delay", n, DLY);
      chk(tx_data == v[8*i +: 8] && !tx_break, "R1", "echo byte", tx_data, v[8*i +: 8]);
      chk(!rx_ready, "R9", "rx_ready while echo pending", rx_ready, 0);
      if (i == stall) begin
        repeat (3) @(negedge clk);
        chk(tx_valid && tx_data == v[8*i +: 8] && !tx_break, "R9", "hold under stall",
            tx_data, v[8*i +: 8]);
      end
      tx_ready = 1; @(posedge clk); #1 tx_ready = 0;
    end
    wait_tx(n);
    chk(n == DLY, "R2", "break delay", n, DLY);
    chk(tx_break && tx_data == 8'h00, "R3", "break offered", {tx_break, tx_data}, 9'h100);
    tx_ready = 1; @(posedge clk); #1 tx_ready = 0;
    @(negedge clk);
    chk(entry_done == 1, "R4", "done pulse", entry_done, 1);
    chk(stat_byte == (pass ? 8'h40 : 8'h00), "R4", "status", stat_byte, pass ? 8'h40 : 8'h00);
    @(negedge clk);
    chk(entry_done == 0, "R4", "done one cycle", entry_done, 0);
  endtask

  task automatic check_access(input bit unl);
    @(negedge clk);
    mem_addr = LO + 16'h0010; #1;
    chk(mem_rdata_out == (unl ? 8'h5C : 8'hAD), "R5", "read in window",
        mem_rdata_out, unl ? 8'h5C : 8'hAD);
    mem_addr = 16'h0100; #1;
    chk(mem_rdata_out == 8'h5C, "R5", "read outside window", mem_rdata_out, 8'h5C);
    fetch_valid = 1; fetch_addr = 16'h0200;
    @(negedge clk);
    chk(rst_req == 0, "R6", "fetch outside window", rst_req, 0);
    fetch_addr = LO + 16'h0004;
    @(negedge clk);
    fetch_valid = 0;
    chk(rst_req == !unl, "R6", "fetch in window", rst_req, !unl);
    @(negedge clk);
    chk(rst_req == 0, "R6", "request is one cycle", rst_req, 0);
  endtask

  task automatic t_reset();
    power_on();
    @(negedge clk);
    chk(stat_byte == 0 && !tx_valid && rx_ready && !rst_req && !entry_done, "R10",
        "reset state", {stat_byte, tx_valid, rx_ready, rst_req, entry_done}, 8'h04);
  endtask

  task automatic t_good();
    power_on(); run_entry(KEY, 1, 2); check_access(1);
  endtask

  task automatic t_bad_last();
    power_on(); run_entry(KEY ^ 64'h0100_0000_0000_0000, 0, -1); check_access(0);
  endtask

  task automatic t_bad_first();
    power_on(); run_entry(KEY ^ 64'h80, 0, -1);
  endtask

  task automatic t_retry_warm();
    bit seen = 0;
    power_on(); run_entry(KEY ^ 64'h10, 0, -1);
    @(negedge clk) wrst_n = 0; @(negedge clk) wrst_n = 1;
    for (int i = 0; i < NK; i++) begin
      send_rx(KEY[8*i +: 8]);
      repeat (DLY + 2) begin @(negedge clk); if (tx_valid) seen = 1; end
    end
    chk(!seen, "R7", "no echo after attempt", seen, 0);
    chk(stat_byte == 8'h00, "R7", "warm reset keeps locked", stat_byte, 0);
    // warm reset in the middle of an entry
    power_on();
    for (int i = 0; i < 2; i++) begin
      int n;
      send_rx(KEY[8*i +: 8]); wait_tx(n);
      tx_ready = 1; @(posedge clk); #1 tx_ready = 0;
    end
    @(negedge clk) wrst_n = 0; @(negedge clk) wrst_n = 1;
    seen = 0;
    for (int i = 2; i < NK; i++) begin
      send_rx(KEY[8*i +: 8]);
      repeat (DLY + 2) begin @(negedge clk); if (tx_valid || entry_done) seen = 1; end
    end
    chk(!seen && stat_byte == 0, "R7", "mid-entry warm reset fails attempt",
        {seen, stat_byte}, 0);
  endtask

  task automatic t_erase();
    power_on();
    @(negedge clk) erase_req = 1; @(negedge clk) erase_req = 0;
    run_entry({8{8'hFF}}, 1, -1);
    power_on();
    @(negedge clk) erase_req = 1; @(negedge clk) erase_req = 0;
    run_entry(KEY, 0, -1);
    chk(stat_byte == 0, "R8", "old key rejected after erase", stat_byte, 0);
  endtask

  initial begin
    t_reset();
    t_good();
    t_bad_last();
    t_bad_first();
    t_retry_warm();
    t_erase();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule